// File: doc/BRIEF.md
# Host Memory Address Remap Decoder

This block takes one physical host address per cycle, with a valid flag, and decides where the access belongs. It checks the address against a small set of region values that arrive as plain inputs. The regions are the low-memory ceiling, the top of memory, three stolen regions stacked beneath the ceiling, and a programmable remap window. It returns a target code, an address for DRAM and a flag that marks a remap hit. The result is registered and leaves exactly one cycle after the address enters. The valid flag travels with it.

The remap window lets DRAM that sits under the low MMIO hole be reached again at a higher address. Its base and limit are given as megabyte numbers. The window covers every byte from the first byte of the base megabyte to the last byte of the limit megabyte. A hit is moved down so that the base lands on the low-memory ceiling. If the base is set above the limit, the window is switched off. The graphics, translation-table and SMM regions are worked out downward from the low-memory ceiling, using three size inputs. Two ranges just below 4 GB are fixed: the firmware reset vector and the interrupt controller range.

Top module: `addr_remap_decoder`

## Requirements
- R1: The remap window is inclusive at megabyte granularity. Any address whose megabyte number (bits 38:20) lies in [remap_base, remap_limit] hits. This covers byte 0 of the base megabyte and byte 0xFFFFF of the limit megabyte. A window with base equal to limit covers exactly one megabyte.
- R2: When remap_base is greater than remap_limit, no address hits the window. out_remap_hit is 0, and the address is classified as if no window existed.
- R3: On a remap hit, out_target is DRAM (code 0) and out_remap_hit is 1. out_addr is ((mb − remap_base + low_ceiling) << 20) | addr[19:0].
- R4: Below 4 GB and outside the window, addresses with megabyte number in [low_ceiling − gfx_size, low_ceiling) give target code 1 (graphics stolen).
- R5: The next gtt_size megabytes directly below the graphics region give target code 2 (translation-table stolen).
- R6: The next smm_size megabytes directly below the translation-table region give target code 3 (SMM segment).
- R7: Addresses 0xFFE0_0000 to 0xFFFF_FFFF (megabytes 4094 and 4095) always give target code 4 (downstream port) with out_remap_hit 0, even when they fall inside the remap window.
- R8: Outside the window, addresses 0xFEC0_0000 to 0xFEEF_FFFF (megabytes 4076 to 4078) give target code 5 (interrupt/MMIO).
- R9: The remap window takes precedence over the stolen regions, the interrupt range and the low MMIO hole. An overlapping address is translated to DRAM.
- R10: Outside the window, four rules apply. Addresses below the SMM region give DRAM (code 0) with the address unchanged. Other addresses from the low ceiling up to 4 GB give the downstream port (code 4). Addresses from 4 GB up to top_of_mem − 1 MB give DRAM with the address unchanged. Addresses at or above top_of_mem give the downstream port.
- R11: Results appear exactly one clock after the input. out_valid equals in_valid of the previous cycle and is 0 while reset is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Address present this cycle |
| in_addr | input | 39 | Physical host address |
| cfg_low_ceil | input | 19 | Low-memory ceiling, in MB |
| cfg_top_mem | input | 19 | Top of memory, in MB |
| cfg_remap_base | input | 19 | First megabyte of the remap window |
| cfg_remap_limit | input | 19 | Last megabyte of the remap window |
| cfg_gfx_size | input | 19 | Graphics stolen size, in MB |
| cfg_gtt_size | input | 19 | Translation-table stolen size, in MB |
| cfg_smm_size | input | 19 | SMM segment size, in MB |
| out_valid | output | 1 | Result valid |
| out_target | output | 3 | 0 DRAM, 1 graphics, 2 translation table, 3 SMM, 4 downstream, 5 interrupt/MMIO |
| out_addr | output | 39 | Translated or unchanged address |
| out_remap_hit | output | 1 | Address was translated by the window |

## Verification
A single address can hit the remap window and one of the low fixed or stolen regions at the same time. The bench provokes this in two ways. It moves the window over the stolen stack and over the interrupt range, and it moves it over the reset-vector megabytes. The outcome is judged by priority. Stolen and interrupt addresses must come back translated to DRAM with the hit flag set. Reset-vector addresses must still go to the downstream port, untranslated and with the hit flag clear. Random addresses clustered around every region edge are then run against a bench model, in both the overlapping and the separated layouts.

// File: rtl/amr_pkg.sv
package amr_pkg;

  typedef enum logic [2:0] {
    TGT_DRAM = 3'd0,
    TGT_GFX  = 3'd1,
    TGT_GTT  = 3'd2,
    TGT_SMM  = 3'd3,
    TGT_DS   = 3'd4,
    TGT_MMIO = 3'd5
  } tgt_e;

  // number of stolen regions stacked below the low ceiling
  localparam int NSTOLEN = 3;

endpackage

// File: rtl/amr_stolen_chain.sv
// Computes lower bounds of stolen regions, each directly beneath the previous
module amr_stolen_chain #(
  parameter int FW = 19,
  parameter int N  = 3
) (
  input  logic [FW-1:0]         ceil_mb,
  input  logic [N-1:0][FW-1:0]  size_mb,
  output logic [N-1:0][FW-1:0]  low_mb
);

  for (genvar k = 0; k < N; k++) begin : g_chain
    if (k == 0) begin : g_first
      assign low_mb[k] = ceil_mb - size_mb[k];
    end else begin : g_next
      assign low_mb[k] = low_mb[k-1] - size_mb[k];
    end
  end

endmodule

// File: rtl/amr_window.sv
// Inclusive megabyte-granular remap window with translation
module amr_window #(
  parameter int AW = 39,
  parameter int GW = 20
) (
  input  logic [AW-1:0]    addr,
  input  logic [AW-GW-1:0] base_mb,
  input  logic [AW-GW-1:0] limit_mb,
  input  logic [AW-GW-1:0] ceil_mb,
  output logic             hit,
  output logic [AW-1:0]    xlat_addr
);

  localparam int FW = AW - GW;

  logic [FW-1:0] mb;
  logic          enabled;
  logic [FW-1:0] dst_mb;

  always_comb begin
    mb        = addr[AW-1:GW];
    enabled   = (base_mb <= limit_mb);
    hit       = enabled && (mb >= base_mb) && (mb <= limit_mb);
    dst_mb    = mb - base_mb + ceil_mb;
    xlat_addr = {dst_mb, addr[GW-1:0]};
  end

endmodule

// File: rtl/amr_classify.sv
// Priority classification of one megabyte number
module amr_classify
  import amr_pkg::*;
#(
  parameter int FW        = 19,
  parameter int GW        = 20,
  parameter int N         = 3,
  parameter int RV_LO_MB  = 4094,
  parameter int INT_LO_MB = 4076,
  parameter int INT_HI_MB = 4078
) (
  input  logic [FW-1:0]        mb,
  input  logic [FW-1:0]        ceil_mb,
  input  logic [FW-1:0]        top_mb,
  input  logic [N-1:0][FW-1:0] low_mb,
  input  logic                 win_hit,
  output tgt_e                 tgt,
  output logic                 eff_hit
);

  localparam logic [FW-1:0] FOUR_G = FW'(1 << (32 - GW));
  localparam logic [FW-1:0] RV_LO  = FW'(RV_LO_MB);
  localparam logic [FW-1:0] INT_LO = FW'(INT_LO_MB);
  localparam logic [FW-1:0] INT_HI = FW'(INT_HI_MB);

  logic below_4g;
  logic in_rv;
  logic in_int;

  always_comb begin
    below_4g = (mb < FOUR_G);
    in_rv    = below_4g && (mb >= RV_LO);
    in_int   = (mb >= INT_LO) && (mb <= INT_HI);
    eff_hit  = 1'b0;
    tgt      = TGT_DRAM;
    if (in_rv) begin
      tgt = TGT_DS;
    end else if (win_hit) begin
      tgt     = TGT_DRAM;
      eff_hit = 1'b1;
    end else if (below_4g) begin
      if (in_int)                 tgt = TGT_MMIO;
      else if (mb >= ceil_mb)     tgt = TGT_DS;
      else if (mb >= low_mb[0])   tgt = TGT_GFX;
      else if (mb >= low_mb[1])   tgt = TGT_GTT;
      else if (mb >= low_mb[2])   tgt = TGT_SMM;
      else                        tgt = TGT_DRAM;
    end else begin
      tgt = (mb < top_mb) ? TGT_DRAM : TGT_DS;
    end
  end

endmodule

// File: rtl/addr_remap_decoder.sv
module addr_remap_decoder
  import amr_pkg::*;
#(
  parameter int ADDR_W    = 39,
  parameter int GRAN_W    = 20,
  parameter int RV_LO_MB  = 4094,
  parameter int INT_LO_MB = 4076,
  parameter int INT_HI_MB = 4078
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [ADDR_W-1:0]        in_addr,
  input  logic [ADDR_W-GRAN_W-1:0] cfg_low_ceil,
  input  logic [ADDR_W-GRAN_W-1:0] cfg_top_mem,
  input  logic [ADDR_W-GRAN_W-1:0] cfg_remap_base,
  input  logic [ADDR_W-GRAN_W-1:0] cfg_remap_limit,
  input  logic [ADDR_W-GRAN_W-1:0] cfg_gfx_size,
  input  logic [ADDR_W-GRAN_W-1:0] cfg_gtt_size,
  input  logic [ADDR_W-GRAN_W-1:0] cfg_smm_size,
  output logic                     out_valid,
  output logic [2:0]               out_target,
  output logic [ADDR_W-1:0]        out_addr,
  output logic                     out_remap_hit
);

  localparam int FW = ADDR_W - GRAN_W;

  logic [NSTOLEN-1:0][FW-1:0] sizes;
  logic [NSTOLEN-1:0][FW-1:0] lows;
  logic                       win_hit;
  logic [ADDR_W-1:0]          xlat;
  tgt_e                       tgt;
  logic                       eff_hit;

  // next-state values
  logic                       valid_d;
  logic [2:0]                 target_d;
  logic [ADDR_W-1:0]          addr_d;
  logic                       hit_d;
  logic                       data_en;

  assign sizes[0] = cfg_gfx_size;
  assign sizes[1] = cfg_gtt_size;
  assign sizes[2] = cfg_smm_size;

  amr_stolen_chain #(.FW(FW), .N(NSTOLEN)) u_chain (
    .ceil_mb (cfg_low_ceil),
    .size_mb (sizes),
    .low_mb  (lows)
  );

  amr_window #(.AW(ADDR_W), .GW(GRAN_W)) u_window (
    .addr      (in_addr),
    .base_mb   (cfg_remap_base),
    .limit_mb  (cfg_remap_limit),
    .ceil_mb   (cfg_low_ceil),
    .hit       (win_hit),
    .xlat_addr (xlat)
  );

  amr_classify #(
    .FW(FW), .GW(GRAN_W), .N(NSTOLEN),
    .RV_LO_MB(RV_LO_MB), .INT_LO_MB(INT_LO_MB), .INT_HI_MB(INT_HI_MB)
  ) u_class (
    .mb      (in_addr[ADDR_W-1:GRAN_W]),
    .ceil_mb (cfg_low_ceil),
    .top_mb  (cfg_top_mem),
    .low_mb  (lows),
    .win_hit (win_hit),
    .tgt     (tgt),
    .eff_hit (eff_hit)
  );

  always_comb begin
    valid_d  = in_valid;
    data_en  = in_valid;
    target_d = tgt;
    hit_d    = eff_hit;
    addr_d   = eff_hit ? xlat : in_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= valid_d;
    end
  end

  always_ff @(posedge clk) begin
    if (data_en) begin
      out_target    <= target_d;
      out_addr      <= addr_d;
      out_remap_hit <= hit_d;
    end
  end

endmodule

// File: rtl/amr_checker.sv
module amr_checker #(
  parameter int ADDR_W   = 39,
  parameter int GRAN_W   = 20,
  parameter int RV_LO_MB = 4094
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     in_valid,
  input logic [ADDR_W-1:0]        in_addr,
  input logic [ADDR_W-GRAN_W-1:0] cfg_remap_base,
  input logic [ADDR_W-GRAN_W-1:0] cfg_remap_limit,
  input logic                     out_valid,
  input logic [2:0]               out_target,
  input logic [ADDR_W-1:0]        out_addr,
  input logic                     out_remap_hit
);

  localparam int FW = ADDR_W - GRAN_W;
  localparam logic [FW-1:0] RV_LO  = FW'(RV_LO_MB);
  localparam logic [FW-1:0] FOUR_G = FW'(1 << (32 - GRAN_W));

  logic in_rv;
  assign in_rv = (in_addr[ADDR_W-1:GRAN_W] >= RV_LO) &&
                 (in_addr[ADDR_W-1:GRAN_W] < FOUR_G);

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R11

  AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R11

  AST_HIT_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_remap_hit) |-> (out_target == 3'd0)); // R3

  AST_DISABLED_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (cfg_remap_base > cfg_remap_limit)) |=> !out_remap_hit); // R2

  AST_PASS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_remap_hit) |-> (out_addr == $past(in_addr))); // R10

  AST_RESET_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_rv) |=> (out_target == 3'd4 && !out_remap_hit)); // R7

endmodule

bind addr_remap_decoder amr_checker #(
  .ADDR_W(ADDR_W), .GRAN_W(GRAN_W), .RV_LO_MB(RV_LO_MB)
) u_amr_checker (
  .clk             (clk),
  .rst_n           (rst_n),
  .in_valid        (in_valid),
  .in_addr         (in_addr),
  .cfg_remap_base  (cfg_remap_base),
  .cfg_remap_limit (cfg_remap_limit),
  .out_valid       (out_valid),
  .out_target      (out_target),
  .out_addr        (out_addr),
  .out_remap_hit   (out_remap_hit)
);

// File: tb/addr_remap_decoder_bench.sv
module addr_remap_decoder_bench;

  localparam int AW = 39;
  localparam int FW = 19;

  logic          clk;
  logic          rst_n;
  logic          in_valid;
  logic [AW-1:0] in_addr;
  logic [FW-1:0] c_ceil, c_top, c_base, c_limit, c_gfx, c_gtt, c_smm;
  logic          out_valid;
  logic [2:0]    out_target;
  logic [AW-1:0] out_addr;
  logic          out_remap_hit;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  addr_remap_decoder u_addr_remap_decoder (
    .clk             (clk),
    .rst_n           (rst_n),
    .in_valid        (in_valid),
    .in_addr         (in_addr),
    .cfg_low_ceil    (c_ceil),
    .cfg_top_mem     (c_top),
    .cfg_remap_base  (c_base),
    .cfg_remap_limit (c_limit),
    .cfg_gfx_size    (c_gfx),
    .cfg_gtt_size    (c_gtt),
    .cfg_smm_size    (c_smm),
    .out_valid       (out_valid),
    .out_target      (out_target),
    .out_addr        (out_addr),
    .out_remap_hit   (out_remap_hit)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // expected result built from the requirement text
  function automatic void model(input logic [AW-1:0] a, output logic [2:0] t,
                                output logic h, output logic [AW-1:0] o);
    logic [FW-1:0] mb;
    logic [FW-1:0] gfx_lo, gtt_lo, smm_lo;
    mb     = a[AW-1:20];
    gfx_lo = c_ceil - c_gfx;
    gtt_lo = gfx_lo - c_gtt;
    smm_lo = gtt_lo - c_smm;
    h = 1'b0;
    o = a;
    if (mb >= 19'd4094 && mb < 19'd4096) t = 3'd4;
    else if (c_base <= c_limit && mb >= c_base && mb <= c_limit) begin
      t = 3'd0; h = 1'b1;
      o = {mb - c_base + c_ceil, a[19:0]};
    end else if (mb < 19'd4096) begin
      if (mb >= 19'd4076 && mb <= 19'd4078) t = 3'd5;
      else if (mb >= c_ceil) t = 3'd4;
      else if (mb >= gfx_lo) t = 3'd1;
      else if (mb >= gtt_lo) t = 3'd2;
      else if (mb >= smm_lo) t = 3'd3;
      else t = 3'd0;
    end else t = (mb < c_top) ? 3'd0 : 3'd4;
  endfunction

  // called at a falling edge; checks the result one clock later
  task automatic apply(input logic [AW-1:0] a, input string req);
    logic [2:0]    et;
    logic          eh;
    logic [AW-1:0] ea;
    in_valid = 1'b1;
    in_addr  = a;
    model(a, et, eh, ea);
    @(negedge clk);
    total++;
    if (out_valid !== 1'b1 || out_target !== et || out_remap_hit !== eh || out_addr !== ea) begin
      bad++;
      $display("FAIL %s addr=%h act v=%b t=%0d h=%b a=%h exp v=1 t=%0d h=%b a=%h",
               req, a, out_valid, out_target, out_remap_hit, out_addr, et, eh, ea);
    end
  endtask

  task automatic idle_check(input string req);
    in_valid = 1'b0;
    @(negedge clk);
    total++;
    if (out_valid !== 1'b0) begin
      bad++;
      $display("FAIL %s out_valid act=%b exp=0", req, out_valid);
    end
  endtask

  function automatic logic [AW-1:0] mba(input int mb, input logic [19:0] lo);
    return {FW'(mb), lo};
  endfunction

  task automatic cfg_default();
    c_ceil = 19'd3072; c_top = 19'd9216;
    c_base = 19'd8192; c_limit = 19'd9215;
    c_gfx = 19'd64; c_gtt = 19'd2; c_smm = 19'd8;
  endtask

  task automatic random_run(input int n, input string req);
    int pts[8];
    pts[0] = int'(c_ceil); pts[1] = int'(c_ceil - c_gfx);
    pts[2] = int'(c_ceil - c_gfx - c_gtt); pts[3] = int'(c_base);
    pts[4] = int'(c_limit); pts[5] = 4096; pts[6] = int'(c_top); pts[7] = 4077;
    for (int i = 0; i < n; i++) begin
      int c;
      int off;
      logic [19:0] lo;
      c   = pts[$urandom % 8];
      off = int'($urandom % 9) - 4;
      lo  = 20'($urandom);
      if (($urandom % 8) == 0) apply(AW'({$urandom, $urandom}), req);
      else apply(mba(c + off, lo), req);
    end
  endtask

  initial begin
    void'($urandom(32'h1357_9bdf));
    rst_n = 1'b0; in_valid = 1'b0; in_addr = '0;
    cfg_default();
    repeat (3) @(negedge clk);
    total++;
    if (out_valid !== 1'b0) begin
      bad++; $display("FAIL R11 reset out_valid act=%b exp=0", out_valid);
    end
    rst_n = 1'b1;
    idle_check("R11");

    // window edges, translation
    apply(mba(8192, 20'h0), "R1");
    apply(mba(9215, 20'hFFFFF), "R1");
    apply(mba(8500, 20'h12345), "R3");
    apply(mba(8191, 20'hFFFFF), "R10");
    apply(mba(9216, 20'h0), "R10");
    apply(mba(5000, 20'h00abc), "R10");
    // stolen chain
    apply(mba(3071, 20'hFFFFF), "R4");
    apply(mba(3008, 20'h0), "R4");
    apply(mba(3007, 20'h5), "R5");
    apply(mba(3006, 20'h0), "R5");
    apply(mba(3005, 20'hFFFFF), "R6");
    apply(mba(2998, 20'h0), "R6");
    apply(mba(2997, 20'hFFFFF), "R10");
    apply(mba(3072, 20'h0), "R10");
    // fixed ranges
    apply(mba(4076, 20'h0), "R8");
    apply(mba(4078, 20'hFFFFF), "R8");
    apply(mba(4075, 20'hFFFFF), "R10");
    apply(mba(4079, 20'h0), "R10");
    apply(mba(4095, 20'hFFFF0), "R7");
    apply(mba(4094, 20'h0), "R7");
    idle_check("R11");

    // single-megabyte window
    c_base = 19'd7000; c_limit = 19'd7000;
    apply(mba(7000, 20'hFFFFF), "R1");
    apply(mba(7001, 20'h0), "R1");
    // disabled window
    c_base = 19'd9000; c_limit = 19'd8500;
    apply(mba(8800, 20'h777), "R2");
    apply(mba(9000, 20'h0), "R2");
    // window over stolen stack and interrupt range
    c_base = 19'd2990; c_limit = 19'd4080;
    apply(mba(3050, 20'h4321), "R9");
    apply(mba(3000, 20'h0), "R9");
    apply(mba(4077, 20'h10), "R9");
    apply(mba(3080, 20'h10), "R9");
    // window over reset vector
    c_base = 19'd4090; c_limit = 19'd4100;
    apply(mba(4095, 20'hFFFF0), "R7");
    apply(mba(4093, 20'h0), "R9");
    random_run(300, "R9");

    cfg_default();
    random_run(400, "R10");
    idle_check("R11");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule